// File: doc/BRIEF.md
# 1-Wire ROM Command and Search Responder

This block is the network layer of a 1-Wire slave node. It runs after each reset/presence exchange and decides whether the node takes part in the function-command phase that follows. A bit-slot front end, outside this block, gives it two strobes. One strobe marks a master write slot and carries the bit the master wrote. The other marks a read slot. In return the block presents `tx_bit`, the level the node puts on the line in the next read slot. A 1 means the node releases the line. A 0 means it pulls the line low.

The block first collects an 8-bit ROM command, least significant bit first. It then runs one of five operations against a 64-bit node identity:

- Read out the identity.
- Match an address sent by the master.
- Skip addressing.
- Search by the three-slot bit/complement/direction exchange.
- Search only while the alarm flag is set.

A node that wins raises `selected`, which hands the bus to the function-command layer. A node that loses goes quiet: it keeps the line released and `selected` low until the next reset. The identity is an input. Its low byte holds the family code, the next 48 bits hold the serial number and the top byte holds the CRC. Bit 0 is sent first.

Top module: `onewire_rom_layer`

## Requirements
- R1: During the command phase the block gathers 8 write slots into a code, the first slot being bit 0. Read slots in this phase are ignored and `tx_bit` stays 1.
- R2: Code 33h (read identity) makes read slot k present `rom_id[k]` for k = 0..63. `selected` rises after the 64th read slot and not before.
- R3: Code 55h (match) compares write slot k with `rom_id[k]`. If all 64 slots are equal, `selected` rises after the 64th slot and not before.
- R4: In match mode, the first write slot that differs from the identity bit makes the node quiet until the next reset. Quiet means `tx_bit` = 1 and `selected` = 0 for every later slot.
- R5: Code CCh (skip) raises `selected` in the cycle after the 8th command bit, with no address phase.
- R6: Code F0h (search) repeats, for each bit k from 0 to 63, a cycle of three slots. The first read slot gives `rom_id[k]` and the second read slot gives its inverse. The block then takes one write slot.
- R7: In a search pass, a write slot whose bit differs from `rom_id[k]` makes the node quiet until the next reset.
- R8: A node that completes all 64 bit positions of a search pass raises `selected`.
- R9: Code ECh (alarm search) behaves as in R6 to R8 when `alarm_flag` is 1 at the 8th command bit. If the flag is 0 at that point, the node is quiet.
- R10: Any other command code makes the node quiet until the next reset.
- R11: A `bus_reset` pulse in any state returns the block to the command phase. On the next cycle `selected` is 0, `tx_bit` is 1, and any partly received command is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse: a bus reset was detected |
| slot_wr | input | 1 | One-cycle pulse: the master wrote a bit |
| slot_rd | input | 1 | One-cycle pulse: a read slot took place |
| slot_bit | input | 1 | Bit written by the master, valid with `slot_wr` |
| alarm_flag | input | 1 | Alarm condition from the measurement side |
| rom_id | input | ID_W | Node identity; bit 0 is sent first |
| tx_bit | output | 1 | Level for the next read slot (1 = release) |
| selected | output | 1 | Node is addressed; function layer owns the bus |

## Verification
The hardest conditions to reach are the states deep inside a search pass. One is a node that drops out at an arbitrary bit position. Another is a node that survives all 192 slots of a pass. Either one is reached only by playing the exact bit, complement and direction sequence for every earlier position. The bench therefore acts as a search master. It reads each pair of bits, checks that the two are inverses and writes back the node's own bit. At a chosen position it writes the inverse bit instead, then keeps issuing slots to confirm the node stays silent. Resets are also placed inside a half-received command and inside a selected node, to cover the return paths.

// File: rtl/rom_layer_pkg.sv
package rom_layer_pkg;

  typedef enum logic [2:0] {
    ST_CMD, ST_READ, ST_MATCH, ST_SRC_BIT, ST_SRC_CMP, ST_SRC_DIR, ST_SEL, ST_QUIET
  } rl_state_t;

  typedef enum logic [2:0] {
    OP_READ, OP_MATCH, OP_SKIP, OP_SEARCH, OP_ALARM, OP_BAD
  } rl_op_t;

  localparam logic [7:0] CODE_READ   = 8'h33;
  localparam logic [7:0] CODE_MATCH  = 8'h55;
  localparam logic [7:0] CODE_SKIP   = 8'hCC;
  localparam logic [7:0] CODE_SEARCH = 8'hF0;
  localparam logic [7:0] CODE_ALARM  = 8'hEC;

  function automatic rl_op_t decode_op(input logic [7:0] code);
    case (code)
      CODE_READ:   return OP_READ;
      CODE_MATCH:  return OP_MATCH;
      CODE_SKIP:   return OP_SKIP;
      CODE_SEARCH: return OP_SEARCH;
      CODE_ALARM:  return OP_ALARM;
      default:     return OP_BAD;
    endcase
  endfunction

  // state entered once a command byte is complete
  function automatic rl_state_t entry_state(input rl_op_t op, input logic alarm);
    case (op)
      OP_READ:   return ST_READ;
      OP_MATCH:  return ST_MATCH;
      OP_SKIP:   return ST_SEL;
      OP_SEARCH: return ST_SRC_BIT;
      OP_ALARM:  return alarm ? ST_SRC_BIT : ST_QUIET;
      default:   return ST_QUIET;
    endcase
  endfunction

  // line level offered for the next read slot
  function automatic logic line_level(input rl_state_t st, input logic own);
    case (st)
      ST_READ, ST_SRC_BIT: return own;
      ST_SRC_CMP:          return ~own;
      default:             return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/rl_cmd_shift.sv
module rl_cmd_shift #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_in,
  output logic             done,
  output logic [CMD_W-1:0] code_out
);
  localparam int CNT_W = $clog2(CMD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);

  logic [CMD_W-1:0] sr;
  logic [CNT_W-1:0] cnt;

  assign code_out = {bit_in, sr[CMD_W-1:1]};
  assign done     = en && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clr) begin
      sr  <= '0;
      cnt <= '0;
    end else if (en) begin
      sr  <= code_out;
      cnt <= done ? '0 : cnt + 1'b1;
    end
  end

  p_cnt_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> (cnt == '0));
endmodule

// File: rtl/rl_bit_cursor.sv
module rl_bit_cursor #(
  parameter int ID_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    adv,
  output logic [$clog2(ID_W)-1:0] idx,
  output logic                    last
);
  localparam int IDX_W = $clog2(ID_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

  assign last = (idx == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (adv) idx <= last ? '0 : idx + 1'b1;
  end

  p_adv_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !last) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/onewire_rom_layer.sv
module onewire_rom_layer
  import rom_layer_pkg::*;
#(
  parameter int ID_W  = 64,
  parameter int CMD_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic            slot_wr,
  input  logic            slot_rd,
  input  logic            slot_bit,
  input  logic            alarm_flag,
  input  logic [ID_W-1:0] rom_id,
  output logic            tx_bit,
  output logic            selected
);
  localparam int IDX_W = $clog2(ID_W);

  rl_state_t        state, nxt;
  logic [IDX_W-1:0] idx;
  logic             last, own_bit;
  logic             cmd_done;
  logic [CMD_W-1:0] cmd_code;
  rl_op_t           op;

  // named internal events
  logic ev_decode, ev_step, ev_mismatch, ev_finish, cmd_en, wr_cmp;

  assign own_bit     = rom_id[idx];
  assign op          = decode_op(cmd_code[7:0]);
  assign cmd_en      = (state == ST_CMD) && slot_wr;
  assign ev_decode   = cmd_done;
  assign wr_cmp      = slot_wr && (state == ST_MATCH || state == ST_SRC_DIR);
  assign ev_mismatch = wr_cmp && (slot_bit != own_bit);
  assign ev_step     = (wr_cmp && (slot_bit == own_bit)) || (state == ST_READ && slot_rd);
  assign ev_finish   = ev_step && last;

  rl_cmd_shift #(.CMD_W(CMD_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .clr(bus_reset), .en(cmd_en),
    .bit_in(slot_bit), .done(cmd_done), .code_out(cmd_code)
  );

  rl_bit_cursor #(.ID_W(ID_W)) u_cur (
    .clk(clk), .rst_n(rst_n), .clr(bus_reset), .adv(ev_step),
    .idx(idx), .last(last)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_CMD:     if (ev_decode) nxt = entry_state(op, alarm_flag);
      ST_READ:    if (ev_finish) nxt = ST_SEL;
      ST_MATCH:   if (ev_mismatch) nxt = ST_QUIET;
                  else if (ev_finish) nxt = ST_SEL;
      ST_SRC_BIT: if (slot_rd) nxt = ST_SRC_CMP;
      ST_SRC_CMP: if (slot_rd) nxt = ST_SRC_DIR;
      ST_SRC_DIR: if (ev_mismatch) nxt = ST_QUIET;
                  else if (ev_finish) nxt = ST_SEL;
                  else if (ev_step) nxt = ST_SRC_BIT;
      ST_SEL:     nxt = ST_SEL;
      ST_QUIET:   nxt = ST_QUIET;
      default:    nxt = ST_QUIET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state <= ST_CMD;
    else if (bus_reset) state <= ST_CMD;
    else                state <= nxt;
  end

  assign tx_bit   = line_level(state, own_bit);
  assign selected = (state == ST_SEL);

  // R11: reset pulse clears selection and releases the line
  p_sel_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!selected && tx_bit));
  // R5: skip selects on the following cycle
  p_skip_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_decode && cmd_code[7:0] == CODE_SKIP && !bus_reset) |=> selected);
  // R6: complement slot offers the inverse of the bit slot
  p_cmp_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SRC_BIT && slot_rd && !bus_reset) |=> (tx_bit == !$past(tx_bit)));
  // R4 / R7: a differing bit makes the node quiet
  p_mismatch_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mismatch && !bus_reset) |=> (!selected && tx_bit));
  // R9: alarm search without alarm stays silent
  p_alarm_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_decode && cmd_code[7:0] == CODE_ALARM && !alarm_flag && !bus_reset)
      |=> (!selected && tx_bit));
  // R10: unknown code goes quiet
  p_bad_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_decode && op == OP_BAD && !bus_reset) |=> (!selected && tx_bit));
  // R8: selection only arises from a decode or a completed address phase
  p_sel_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> $past(ev_decode || ev_finish));
endmodule

// File: tb/sim_onewire_rom_layer.sv
`timescale 1ns/1ps
module sim_onewire_rom_layer;
  localparam logic [63:0] ROM = 64'h5B00_0801_9C3A_2E10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_reset = 0, slot_wr = 0, slot_rd = 0, slot_bit = 0, alarm_flag = 0;
  logic tx_bit, selected;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  onewire_rom_layer u0 (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .slot_wr(slot_wr),
    .slot_rd(slot_rd), .slot_bit(slot_bit), .alarm_flag(alarm_flag),
    .rom_id(ROM), .tx_bit(tx_bit), .selected(selected)
  );

  typedef struct packed {
    logic [7:0] code;
    logic       alarm;
    logic       exp_sel;
    logic       exp_tx;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'hCC, 1'b0, 1'b1, 1'b1},  // R5 skip
    '{8'h33, 1'b0, 1'b0, ROM[0]},// R2 read
    '{8'hF0, 1'b0, 1'b0, ROM[0]},// R6 search
    '{8'hEC, 1'b1, 1'b0, ROM[0]},// R9 alarm set
    '{8'hEC, 1'b0, 1'b0, 1'b1},  // R9 alarm clear
    '{8'h55, 1'b0, 1'b0, 1'b1},  // R3 match waits for writes
    '{8'h00, 1'b0, 1'b0, 1'b1},  // R10 unknown
    '{8'h5A, 1'b1, 1'b0, 1'b1}   // R10 unknown
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_bit(input logic b);
    slot_wr = 1'b1; slot_bit = b;
    @(negedge clk);
    slot_wr = 1'b0;
  endtask

  task automatic rd_bit(output logic b);
    b = tx_bit;
    slot_rd = 1'b1;
    @(negedge clk);
    slot_rd = 1'b0;
  endtask

  task automatic pulse_reset();
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) wr_bit(c[i]);
  endtask

  // search pass; drop_at < 0 means follow own identity throughout
  task automatic search_pass(input int drop_at, output logic [63:0] bits,
                             output logic [63:0] cmps);
    logic b, c;
    for (int i = 0; i < 64; i++) begin
      rd_bit(b); rd_bit(c);
      bits[i] = b; cmps[i] = c;
      wr_bit((i == drop_at) ? ~ROM[i] : ROM[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic b;
    logic [63:0] w, c;
    int zeros;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset selected", selected, 0);
    check("R1 reset tx", tx_bit, 1);

    // table walk
    foreach (VEC[k]) begin
      pulse_reset();
      alarm_flag = VEC[k].alarm;
      send_cmd(VEC[k].code);
      check($sformatf("R1 vec%0d selected", k), selected, VEC[k].exp_sel);
      check($sformatf("R1 vec%0d tx", k), tx_bit, VEC[k].exp_tx);
    end
    alarm_flag = 0;

    // R1: read slot inside command phase ignored
    pulse_reset();
    for (int i = 0; i < 4; i++) wr_bit(8'hCC >> i);
    rd_bit(b);
    check("R1 tx during command", b, 1);
    for (int i = 4; i < 8; i++) wr_bit(8'hCC >> i);
    check("R1 skip after read slot", selected, 1);

    // R2 read identity
    pulse_reset(); send_cmd(8'h33);
    for (int i = 0; i < 64; i++) begin
      if (i == 63) check("R2 not selected early", selected, 0);
      rd_bit(b); w[i] = b;
    end
    check("R2 identity bits", w, ROM);
    check("R2 selected", selected, 1);

    // R3 full match
    pulse_reset(); send_cmd(8'h55);
    for (int i = 0; i < 64; i++) begin
      if (i == 63) check("R3 not selected early", selected, 0);
      wr_bit(ROM[i]);
    end
    check("R3 selected", selected, 1);

    // R4 mismatch at bit 5
    pulse_reset(); send_cmd(8'h55);
    for (int i = 0; i < 64; i++) wr_bit(i == 5 ? ~ROM[i] : ROM[i]);
    check("R4 not selected", selected, 0);
    zeros = 0;
    for (int i = 0; i < 16; i++) begin rd_bit(b); if (!b) zeros++; end
    check("R4 quiet line", zeros, 0);

    // R6 / R8 full search pass
    pulse_reset(); send_cmd(8'hF0);
    search_pass(-1, w, c);
    check("R6 bit slots", w, ROM);
    check("R6 complement slots", c, ~ROM);
    check("R8 selected", selected, 1);

    // R7 drop at bit 10
    pulse_reset(); send_cmd(8'hF0);
    search_pass(10, w, c);
    check("R7 bits before drop", w[10:0], ROM[10:0]);
    check("R7 silent after drop", {w[63:11], c[63:11]}, {106{1'b1}});
    check("R7 not selected", selected, 0);

    // R9 alarm search both ways
    pulse_reset(); alarm_flag = 1; send_cmd(8'hEC); alarm_flag = 0;
    search_pass(-1, w, c);
    check("R9 alarm bits", w, ROM);
    check("R9 alarm selected", selected, 1);
    pulse_reset(); send_cmd(8'hEC);
    search_pass(-1, w, c);
    check("R9 no alarm silent", w & c, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R9 no alarm not selected", selected, 0);

    // R10 unknown code, then identity-shaped traffic
    pulse_reset(); send_cmd(8'h5A);
    for (int i = 0; i < 64; i++) wr_bit(ROM[i]);
    zeros = 0;
    for (int i = 0; i < 64; i++) begin rd_bit(b); if (!b) zeros++; end
    check("R10 quiet line", zeros, 0);
    check("R10 not selected", selected, 0);

    // R11 reset while selected and mid-command
    pulse_reset(); send_cmd(8'hCC);
    check("R11 pre selected", selected, 1);
    pulse_reset();
    check("R11 cleared", selected, 0);
    check("R11 tx released", tx_bit, 1);
    for (int i = 0; i < 3; i++) wr_bit(1'b1);
    pulse_reset();
    send_cmd(8'h33);
    check("R11 fresh command", tx_bit, ROM[0]);
    for (int i = 0; i < 8; i++) begin rd_bit(b); w[i] = b; end
    check("R11 first byte", w[7:0], ROM[7:0]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule